// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Status Unit

This block gathers interrupt events for a communications controller and presents them to a processor through a small synchronous register bus. Five direct event sources feed a top-level status register. Three more top-level bits summarise three extended event groups: the D channel, B1 and B2. Each extended group keeps its own eight-bit status register, which latches single-cycle event pulses and clears when it is read.

A mask register decides which top-level bits are visible. A masked event is not lost. It stays pending inside the block and reads as zero until its mask bit is cleared, and then it appears in the status register and on the interrupt line. A single summary mask bit hides a whole extended group from the status register and from the interrupt output, while that group's register keeps latching events.

The interrupt output is a registered level. It is the OR of all visible top-level status bits, one clock after they change. Event generators are outside the block. Each one is seen only as a one-cycle pulse on an input bit.

Top module: `irq_status_unit`

## Requirements
- R1: The mask register is at address 0x18. It can be read and written, and it resets to 0xFF, so every source starts masked.
- R2: The top-level status register is at address 0x14.
  - Its bits are: 7 receive-message-ready, 6 receive-message-end, 5 transmit-ready, 4 external-1, 3 external-0, 2 D summary, 1 B1 summary, 0 B2 summary.
  - These map to `dir_evt[4:0]` as bits 7..3.
  - The mask uses the same bit positions. A mask bit of 1 makes the matching status bit read as 0.
- R3: A direct event that arrives while it is masked stays pending. When its mask bit is written to 0, it reads as 1 in the status register.
- R4: `irq` is the OR of the visible (unmasked) top-level status bits. It updates one clock after the visible status changes.
- R5: Each summary status bit is the OR of its extended register's bits. Setting that summary mask bit removes the whole group from the status register and from `irq`, but the group's register keeps latching events.
- R6: The extended registers are at 0x1C (D), 0x1D (B1) and 0x1E (B2). Each resets to 0x00, sets bit i on a pulse of event bit i, and clears on read, after which its summary bit falls.
- R7: The D extended register bit order, from MSB to LSB, is: receive overflow, transmit underrun, transmit collision, timer-2 expiry, monitor change, indication change, timer-A expiry, timer-B expiry. These are carried on `d_evt[7:0]` in the same order.
- R8: An event pulse in the same cycle as a read-clear of its register wins. The read returns the old value, and the bit is set afterwards.
- R9: Reading the top-level status register clears only the direct bits it returned as 1. Masked pending bits are kept.
- R10: A read from any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read-clear takes effect at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle that bus_rd is high |
| dir_evt | input | 5 | Direct event pulses (status bits 7..3) |
| d_evt | input | 8 | D-channel extended event pulses |
| b1_evt | input | 8 | B1 extended event pulses |
| b2_evt | input | 8 | B2 extended event pulses |
| irq | output | 1 | Registered interrupt level |

## Verification
The bench targets these corner cases:
- **Hidden event.** An event raised under a mask must surface after unmasking. A design that drops masked events would read zero there.
- **Partially masked read.** A top-level read with some bits masked must keep the hidden bits. A design that cleared the whole register would lose them.
- **Event during read-clear.** A pulse in the same cycle as a read-clear must survive. A design that lets the clear win would return zero on the next read.
- **Summary masking.** A masked summary must keep both `irq` and the status bit low. When it is unmasked, both must reflect the group again.

The bench also checks the summary bit falling after a group read, and the D-channel bit order.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int DATA_W      = 8;
   localparam int ADDR_W      = 8;
   localparam int NUM_DIRECT  = 5;
   localparam int NUM_GROUPS  = 3;
   localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h14;
   localparam logic [ADDR_W-1:0] MASK_ADDR = 8'h18;
   localparam logic [ADDR_W-1:0] EXT_BASE  = 8'h1C;

   // group index g sits at summary bit g; D is the highest group
   function automatic logic [ADDR_W-1:0] ext_addr(input int g, input int ngrp);
      return EXT_BASE + ADDR_W'(ngrp - 1 - g);
   endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int              W       = 8,
   parameter logic [W-1:0]    RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask
);
   logic [W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     mask_q <= RST_VAL;
      else if (wr_en) mask_q <= wdata;
   end
   assign mask = mask_q;

   // R1
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/irq_ext_group.sv
module irq_ext_group #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         rd_clr,
   output logic [W-1:0] stat,
   output logic         summary
);
   logic [W-1:0] stat_q;
   logic [W-1:0] stat_d;

   always_comb begin
      stat_d = rd_clr ? '0 : stat_q;
      stat_d = stat_d | evt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   assign stat    = stat_q;
   assign summary = |stat_q;

   // R6
   ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && (evt == '0)) |=> (stat_q == '0));
   // R8
   ext_evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_top_status.sv
module irq_top_status #(
   parameter int NUM_DIRECT = 5,
   parameter int NUM_GROUPS = 3,
   parameter bit REG_IRQ    = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_DIRECT-1:0]            dir_evt,
   input  logic [NUM_GROUPS-1:0]            grp_sum,
   input  logic [NUM_DIRECT+NUM_GROUPS-1:0] mask,
   input  logic                             rd_clr,
   output logic [NUM_DIRECT+NUM_GROUPS-1:0] vis,
   output logic                             irq
);
   localparam int W = NUM_DIRECT + NUM_GROUPS;

   logic [NUM_DIRECT-1:0] pend_q;
   logic [NUM_DIRECT-1:0] pend_d;
   logic [NUM_DIRECT-1:0] clr_bits;
   logic [NUM_DIRECT-1:0] hidden;

   assign vis    = {pend_q, grp_sum} & ~mask;
   assign hidden = pend_q & mask[W-1:NUM_GROUPS];

   always_comb begin
      clr_bits = rd_clr ? vis[W-1:NUM_GROUPS] : '0;
      pend_d   = (pend_q & ~clr_bits) | dir_evt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |vis;
         end
         assign irq = irq_q;

         // R4
         irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vis != '0) |=> irq);
         // R4
         irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vis == '0) |=> !irq);
      end else begin : g_irq_comb
         assign irq = |vis;
      end
   endgenerate

   // R9
   hidden_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> ((pend_q & $past(hidden)) == $past(hidden)));
   // R3
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_evt != '0) |=> ((pend_q & $past(dir_evt)) == $past(dir_evt)));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
   import irq_pkg::*;
#(
   parameter int GRP_W   = 8,
   parameter bit REG_IRQ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_DIRECT-1:0] dir_evt,
   input  logic [GRP_W-1:0]  d_evt,
   input  logic [GRP_W-1:0]  b1_evt,
   input  logic [GRP_W-1:0]  b2_evt,
   output logic              irq
);
   localparam int TOP_W = NUM_DIRECT + NUM_GROUPS;

   generate
      if (TOP_W != DATA_W) begin : g_bad_top_w
         $error("direct plus group count must fill the data width");
      end
      if (GRP_W != DATA_W) begin : g_bad_grp_w
         $error("group register width must equal the data width");
      end
      if (NUM_GROUPS != 3) begin : g_bad_grp_n
         $error("exactly three extended groups are wired");
      end
   endgenerate

   logic [NUM_GROUPS-1:0][GRP_W-1:0] grp_evt;
   logic [NUM_GROUPS-1:0][GRP_W-1:0] grp_stat;
   logic [NUM_GROUPS-1:0]            grp_sel;
   logic [NUM_GROUPS-1:0]            grp_sum;
   logic [TOP_W-1:0]                 mask;
   logic [TOP_W-1:0]                 vis;
   logic                             sel_stat;
   logic                             sel_mask;

   assign grp_evt  = {d_evt, b1_evt, b2_evt};
   assign sel_stat = (bus_addr == STAT_ADDR);
   assign sel_mask = (bus_addr == MASK_ADDR);

   irq_mask_reg #(.W(TOP_W), .RST_VAL('1)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (bus_wr && sel_mask),
      .wdata (bus_wdata),
      .mask  (mask)
   );

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         assign grp_sel[g] = (bus_addr == ext_addr(g, NUM_GROUPS));
         irq_ext_group #(.W(GRP_W)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (grp_evt[g]),
            .rd_clr  (bus_rd && grp_sel[g]),
            .stat    (grp_stat[g]),
            .summary (grp_sum[g])
         );
      end
   endgenerate

   irq_top_status #(
      .NUM_DIRECT (NUM_DIRECT),
      .NUM_GROUPS (NUM_GROUPS),
      .REG_IRQ    (REG_IRQ)
   ) u_top (
      .clk     (clk),
      .rst_n   (rst_n),
      .dir_evt (dir_evt),
      .grp_sum (grp_sum),
      .mask    (mask),
      .rd_clr  (bus_rd && sel_stat),
      .vis     (vis),
      .irq     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_stat)      bus_rdata = vis;
         else if (sel_mask) bus_rdata = mask;
         else begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
               if (grp_sel[g]) bus_rdata = grp_stat[g];
            end
         end
      end
   end

   // R5
   grp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[NUM_GROUPS-1:0] == '1 && vis[TOP_W-1:NUM_GROUPS] == '0) |-> (vis == '0));
   // R10
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !sel_stat && !sel_mask && grp_sel == '0) |-> (bus_rdata == '0));
endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [4:0] dir_evt = '0;
   logic [7:0] d_evt = '0, b1_evt = '0, b2_evt = '0;
   logic       irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   irq_status_unit u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dir_evt(dir_evt), .d_evt(d_evt), .b1_evt(b1_evt), .b2_evt(b2_evt),
      .irq(irq)
   );

   // monitor: compares read data against the scoreboard mid-cycle
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         if (bus_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (bus_rdata !== e) begin
               n_fail++;
               $display("FAIL %s: rdata actual=%02h expected=%02h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t,
                     input logic [4:0] de = '0, input logic [7:0] dd = '0);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; dir_evt = de; d_evt = dd;
      @(negedge clk);
      bus_rd = 1'b0; dir_evt = '0; d_evt = '0;
   endtask

   task automatic pulse(input logic [4:0] de, input logic [7:0] dd,
                        input logic [7:0] b1, input logic [7:0] b2);
      @(negedge clk);
      dir_evt = de; d_evt = dd; b1_evt = b1; b2_evt = b2;
      @(negedge clk);
      dir_evt = '0; d_evt = '0; b1_evt = '0; b2_evt = '0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk);
      @(negedge clk);
      #(CLK_P/4);
      n_tests++;
      if (irq !== e) begin
         n_fail++;
         $display("FAIL %s: irq actual=%0b expected=%0b", t, irq, e);
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h18, 8'hFF, "R1 mask reset");
      rd(8'h14, 8'h00, "R2 status reset");
      chk_irq(1'b0, "R4 irq reset");

      // R3 masked direct event hidden then surfaced
      pulse(5'b10000, 8'h00, 8'h00, 8'h00);
      rd(8'h14, 8'h00, "R2 masked bit reads zero");
      chk_irq(1'b0, "R4 masked no irq");
      wr(8'h18, 8'h7F);
      chk_irq(1'b1, "R4 irq after unmask");
      rd(8'h14, 8'h80, "R3 pending surfaces");
      rd(8'h14, 8'h00, "R9 returned bit cleared");
      chk_irq(1'b0, "R4 irq falls");

      // R9 partial mask: bit6 stays hidden across a read
      wr(8'h18, 8'h47);
      pulse(5'b11000, 8'h00, 8'h00, 8'h00);
      rd(8'h14, 8'h80, "R9 only visible returned");
      wr(8'h18, 8'h00);
      rd(8'h14, 8'h40, "R9 hidden kept");
      rd(8'h14, 8'h00, "R9 cleared after visible read");

      // R6 R7 D group
      pulse(5'b00000, 8'h21, 8'h00, 8'h00);
      rd(8'h14, 8'h04, "R5 D summary");
      chk_irq(1'b1, "R4 irq from group");
      rd(8'h1C, 8'h21, "R7 D bit order");
      rd(8'h1C, 8'h00, "R6 D clears on read");
      rd(8'h14, 8'h00, "R6 summary falls");
      chk_irq(1'b0, "R4 irq falls after group read");

      // R5 summary mask hides the group
      wr(8'h18, 8'h04);
      pulse(5'b00000, 8'h80, 8'h00, 8'h00);
      rd(8'h14, 8'h00, "R5 masked group");
      chk_irq(1'b0, "R5 masked group no irq");
      wr(8'h18, 8'h00);
      rd(8'h14, 8'h04, "R5 group visible after unmask");
      chk_irq(1'b1, "R5 irq after group unmask");
      rd(8'h1C, 8'h80, "R5 group kept latching");

      // R8 event during read-clear
      pulse(5'b00000, 8'h10, 8'h00, 8'h00);
      rd(8'h1C, 8'h10, "R8 ext read old value", 5'b00000, 8'h02);
      rd(8'h1C, 8'h02, "R8 ext event survives");
      pulse(5'b10000, 8'h00, 8'h00, 8'h00);
      rd(8'h14, 8'h80, "R8 top read old value", 5'b10000, 8'h00);
      rd(8'h14, 8'h80, "R8 top event survives");
      rd(8'h14, 8'h00, "R8 top cleared");

      // R6 B1 and B2 groups
      pulse(5'b00000, 8'h00, 8'h03, 8'h80);
      rd(8'h14, 8'h03, "R6 B1 B2 summaries");
      rd(8'h1E, 8'h80, "R6 B2 read");
      rd(8'h14, 8'h02, "R6 B2 summary falls");
      rd(8'h1D, 8'h03, "R6 B1 read");
      rd(8'h14, 8'h00, "R6 all clear");

      // R1 readback, R10 unmapped
      wr(8'h18, 8'h5A);
      rd(8'h18, 8'h5A, "R1 mask readback");
      rd(8'h33, 8'h00, "R10 unmapped read");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: actual=%0d left expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule